// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block sits between a processor-side word port and a slower word-wide memory port. It stores eight one-word lines, organised as four sets of two ways. Each request is compared against both ways of its set at the same time. A hit returns in the cycle after the request is accepted and makes no memory access. A miss stalls the processor port. If the chosen victim line is dirty, the block first writes that line back to memory. It then reads the requested word from memory and answers.

Stores are write-back and write-allocate. A store that hits changes only the cached copy and marks the line dirty. A store that misses first brings the line in, then merges the new word into it. Each set has one replacement bit. A pulse on the flush input walks every line and writes back every dirty one. Two counters report how many accepted requests hit and how many missed.

Addresses on both ports are word addresses, equal to the byte address divided by four. With the default five-bit word address, the port covers a 128-byte memory.

Top module: `wb_set_cache`

## Requirements
- R1: The set index is the low two bits of the word address, bits [1:0], which equals (byte address / 4) mod 4. The tag is the remaining upper bits, [4:2]. Words whose addresses are equal mod 4 compete for the same two ways.
- R2: A request accepted while `req_ready` is high that hits is answered by `rsp_valid` on the next cycle, with no memory transaction, and `hit_count` increases by one.
- R3: An accepted request that misses increases `miss_count` by one. It is answered only after a memory read of the requested word completes, and a read returns the word memory held.
- R4: A store hit updates only the cached word and marks the line dirty. No memory write occurs, and a later load of that word returns the stored value.
- R5: On a miss, the victim is an invalid way if there is one, way 0 first. Otherwise the victim is the least recently used way of the set. Both hits and fills mark the touched way as most recently used.
- R6: When the victim is valid and dirty, its word is written to memory at its own address before the read for the new word is issued.
- R7: A store miss reads the word from memory, then overwrites it with the store data. The line is left dirty, so memory keeps its old value until a writeback.
- R8: `req_ready` is low whenever a memory transaction, a pending refill or a flush is in progress. It is high in the cycle after a hit.
- R9: A flush request writes back every valid dirty line exactly once and clears each line's dirty bit. It leaves clean lines in place. `flush_busy` is high while the walk runs. A second flush with no stores in between writes nothing.
- R10: From reset, loads to byte addresses 0, 32, 0, 24, 32, 64 give miss, miss, hit, miss, hit, miss.
- R11: After reset all lines are invalid, both counters are zero, `req_ready` is high, and `rsp_valid`, `mem_valid` and `flush_busy` are low.
- R12: `mem_valid`, `mem_we` and `mem_word` hold steady until `mem_ready` completes the transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_we | input | 1 | 1 = store, 0 = load |
| req_word | input | WORD_AW | Word address of the request |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle pulse carrying the answer |
| rsp_rdata | output | DATA_W | Load data, or the stored word for a store |
| flush_req | input | 1 | Start a writeback walk of all lines |
| flush_busy | output | 1 | Walk in progress |
| mem_valid | output | 1 | Memory transaction requested |
| mem_we | output | 1 | 1 = writeback, 0 = refill read |
| mem_word | output | WORD_AW | Word address of the memory transaction |
| mem_wdata | output | DATA_W | Writeback data |
| mem_ready | input | 1 | Memory completes the transaction this cycle |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ready` on a read |
| hit_count | output | CNT_W | Accepted requests that hit |
| miss_count | output | CNT_W | Accepted requests that missed |

## Verification
The short trace from reset pins down the basic hit and miss outcomes. A three-tag sequence inside one set separates a true LRU choice from a fixed-way or round-robin choice. Directed store sequences separate write-back behaviour from write-through behaviour: a store hit must leave memory untouched, and a dirty eviction must write first and then read. They also separate write-allocate from write-around. A long pseudo-random mix of loads and stores over all 32 words is compared against an arithmetic model of tags, dirty bits and replacement bits, and is followed by flushes whose memory image and write counts must match the model.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBACK,
    ST_REFILL,
    ST_FSCAN,
    ST_FWB
  } wbc_state_e;
endpackage

// File: rtl/wbc_way_compare.sv
module wbc_way_compare #(
  parameter int TAG_W = 3
) (
  input  logic [1:0]         vld,
  input  logic [2*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]   key,
  output logic               hit,
  output logic               way
);
  logic [1:0] match;

  for (genvar g = 0; g < 2; g++) begin : g_way
    assign match[g] = vld[g] && (tags[g*TAG_W +: TAG_W] == key);
  end

  assign hit = |match;
  assign way = match[1];
endmodule

// File: rtl/wbc_victim_pick.sv
module wbc_victim_pick (
  input  logic [1:0] vld,
  input  logic       lru,
  output logic       way
);
  always_comb begin
    if (!vld[0])      way = 1'b0;
    else if (!vld[1]) way = 1'b1;
    else              way = lru;
  end
endmodule

// File: rtl/wbc_event_ctr.sv
module wbc_event_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/wb_set_cache.sv
module wb_set_cache
  import wbc_pkg::*;
#(
  parameter int WORD_AW = 5,
  parameter int DATA_W  = 32,
  parameter int SETS    = 4,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [WORD_AW-1:0] req_word,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic               flush_req,
  output logic               flush_busy,
  output logic               mem_valid,
  output logic               mem_we,
  output logic [WORD_AW-1:0] mem_word,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ready,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [CNT_W-1:0]   hit_count,
  output logic [CNT_W-1:0]   miss_count
);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = WORD_AW - SET_W;
  localparam int LINES  = 2 * SETS;
  localparam int FIDX_W = SET_W + 1;

  function automatic logic [SET_W-1:0] set_of(input logic [WORD_AW-1:0] w);
    return w[SET_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [WORD_AW-1:0] w);
    return w[WORD_AW-1:SET_W];
  endfunction

  function automatic logic [WORD_AW-1:0] line_word(input logic [TAG_W-1:0] t,
                                                   input logic [SET_W-1:0] s);
    return {t, s};
  endfunction

  // Line storage
  logic [1:0]        v_q   [SETS];
  logic [1:0]        d_q   [SETS];
  logic [TAG_W-1:0]  t_q   [SETS][2];
  logic [DATA_W-1:0] w_q   [SETS][2];
  logic [SETS-1:0]   lru_q;

  wbc_state_e        state_q;
  logic [SET_W-1:0]  p_set;
  logic [TAG_W-1:0]  p_tag;
  logic              p_we;
  logic [DATA_W-1:0] p_wdata;
  logic              p_way;
  logic [FIDX_W-1:0] f_idx;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  // Lookup of the incoming request
  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_hit, lk_way, vic_way, vic_dirty;

  assign lk_set = set_of(req_word);
  assign lk_tag = tag_of(req_word);

  wbc_way_compare #(.TAG_W(TAG_W)) u_cmp (
    .vld  (v_q[lk_set]),
    .tags ({t_q[lk_set][1], t_q[lk_set][0]}),
    .key  (lk_tag),
    .hit  (lk_hit),
    .way  (lk_way)
  );

  wbc_victim_pick u_vic (
    .vld (v_q[lk_set]),
    .lru (lru_q[lk_set]),
    .way (vic_way)
  );

  assign vic_dirty = v_q[lk_set][vic_way] && d_q[lk_set][vic_way];

  // Named events for the checker
  logic ev_accept, ev_hit, ev_miss;
  assign req_ready = (state_q == ST_IDLE) && !flush_req;
  assign ev_accept = req_valid && req_ready;
  assign ev_hit    = ev_accept && lk_hit;
  assign ev_miss   = ev_accept && !lk_hit;

  // Flush walk position
  logic [SET_W-1:0] f_set;
  logic             f_way, f_last;
  assign f_set  = f_idx[FIDX_W-1:1];
  assign f_way  = f_idx[0];
  assign f_last = (f_idx == FIDX_W'(LINES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      lru_q       <= '0;
      p_set       <= '0;
      p_tag       <= '0;
      p_we        <= 1'b0;
      p_wdata     <= '0;
      p_way       <= 1'b0;
      f_idx       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        v_q[s] <= '0;
        d_q[s] <= '0;
        for (int k = 0; k < 2; k++) begin
          t_q[s][k] <= '0;
          w_q[s][k] <= '0;
        end
      end
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (flush_req) begin
            f_idx   <= '0;
            state_q <= ST_FSCAN;
          end else if (ev_hit) begin
            if (req_we) begin
              w_q[lk_set][lk_way] <= req_wdata;
              d_q[lk_set][lk_way] <= 1'b1;
            end
            rsp_rdata_q     <= req_we ? req_wdata : w_q[lk_set][lk_way];
            rsp_valid_q     <= 1'b1;
            lru_q[lk_set]   <= ~lk_way;
          end else if (ev_miss) begin
            p_set   <= lk_set;
            p_tag   <= lk_tag;
            p_we    <= req_we;
            p_wdata <= req_wdata;
            p_way   <= vic_way;
            state_q <= vic_dirty ? ST_WBACK : ST_REFILL;
          end
        end
        ST_WBACK: begin
          if (mem_ready) state_q <= ST_REFILL;
        end
        ST_REFILL: begin
          if (mem_ready) begin
            v_q[p_set][p_way] <= 1'b1;
            d_q[p_set][p_way] <= p_we;
            t_q[p_set][p_way] <= p_tag;
            w_q[p_set][p_way] <= p_we ? p_wdata : mem_rdata;
            lru_q[p_set]      <= ~p_way;
            rsp_rdata_q       <= p_we ? p_wdata : mem_rdata;
            rsp_valid_q       <= 1'b1;
            state_q           <= ST_IDLE;
          end
        end
        ST_FSCAN: begin
          if (v_q[f_set][f_way] && d_q[f_set][f_way]) state_q <= ST_FWB;
          else if (f_last)                            state_q <= ST_IDLE;
          else                                        f_idx   <= f_idx + 1'b1;
        end
        ST_FWB: begin
          if (mem_ready) begin
            d_q[f_set][f_way] <= 1'b0;
            if (f_last) state_q <= ST_IDLE;
            else begin
              f_idx   <= f_idx + 1'b1;
              state_q <= ST_FSCAN;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Memory port
  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_word  = '0;
    mem_wdata = '0;
    case (state_q)
      ST_WBACK: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_word  = line_word(t_q[p_set][p_way], p_set);
        mem_wdata = w_q[p_set][p_way];
      end
      ST_REFILL: begin
        mem_valid = 1'b1;
        mem_word  = line_word(p_tag, p_set);
      end
      ST_FWB: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_word  = line_word(t_q[f_set][f_way], f_set);
        mem_wdata = w_q[f_set][f_way];
      end
      default: ;
    endcase
  end

  assign flush_busy = (state_q == ST_FSCAN) || (state_q == ST_FWB);
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_rdata_q;

  wbc_event_ctr #(.W(CNT_W)) u_hits (
    .clk (clk), .rst_n (rst_n), .inc (ev_hit), .count (hit_count)
  );
  wbc_event_ctr #(.W(CNT_W)) u_misses (
    .clk (clk), .rst_n (rst_n), .inc (ev_miss), .count (miss_count)
  );
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int WORD_AW = 5,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               req_we,
  input logic               rsp_valid,
  input logic               mem_valid,
  input logic               mem_we,
  input logic               mem_ready,
  input logic [WORD_AW-1:0] mem_word,
  input logic               flush_busy,
  input logic               ev_hit,
  input logic               ev_miss,
  input logic [CNT_W-1:0]   miss_count
);
  a_r8_mem_blocks_port: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  a_r9_flush_blocks_port: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !req_ready);

  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_word) && $stable(mem_we));

  a_r2_hit_answers_next: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> rsp_valid && !mem_valid && req_ready);

  a_r4_store_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit && req_we |=> !mem_valid);

  a_r3_miss_counted: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> miss_count == $past(miss_count) + 1'b1);

  a_r3_no_answer_during_mem: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !rsp_valid);

  a_r6_writeback_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && mem_ready && !flush_busy |=> mem_valid && !mem_we);
endmodule

bind wb_set_cache wbc_checker #(.WORD_AW(WORD_AW), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .req_we     (req_we),
  .rsp_valid  (rsp_valid),
  .mem_valid  (mem_valid),
  .mem_we     (mem_we),
  .mem_ready  (mem_ready),
  .mem_word   (mem_word),
  .flush_busy (flush_busy),
  .ev_hit     (ev_hit),
  .ev_miss    (ev_miss),
  .miss_count (miss_count)
);

// File: tb/tb_wb_set_cache.sv
module tb_wb_set_cache;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        req_valid, req_we;
  logic [4:0]  req_word;
  logic [31:0] req_wdata;
  wire         req_ready, rsp_valid;
  wire  [31:0] rsp_rdata;
  logic        flush_req;
  wire         flush_busy;
  wire         mem_valid, mem_we;
  wire  [4:0]  mem_word;
  wire  [31:0] mem_wdata;
  wire         mem_ready;
  wire  [31:0] mem_rdata;
  wire  [15:0] hit_count, miss_count;

  wb_set_cache dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_word(req_word), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .flush_req(flush_req),
    .flush_busy(flush_busy), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_word(mem_word), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .hit_count(hit_count), .miss_count(miss_count)
  );

  int checks = 0;
  int fails  = 0;
  int ops    = 0;
  bit done   = 0;

  // Memory model: answers two cycles after a request appears
  logic [31:0] mem [32];
  logic [1:0]  lat;
  int          cyc = 0, wr_cnt = 0, rd_cnt = 0, last_wr_cyc = 0, last_rd_cyc = 0;
  logic [4:0]  last_wr_word;

  function automatic logic [31:0] seed_word(input int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0203;
  endfunction

  assign mem_ready = mem_valid && (lat == 2'd2);
  assign mem_rdata = mem[mem_word];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      lat <= '0;
      for (int i = 0; i < 32; i++) mem[i] <= seed_word(i);
    end else begin
      if (!mem_valid || mem_ready) lat <= '0;
      else                         lat <= lat + 1'b1;
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          mem[mem_word] <= mem_wdata;
          wr_cnt        <= wr_cnt + 1;
          last_wr_cyc   <= cyc;
          last_wr_word  <= mem_word;
        end else begin
          rd_cnt      <= rd_cnt + 1;
          last_rd_cyc <= cyc;
        end
      end
    end
  end

  // Reference model: set = word mod 4, tag = word / 4
  bit          rv   [4][2];
  bit          rdty [4][2];
  int          rt   [4][2];
  logic [31:0] rdat [4][2];
  bit          rlru [4];
  logic [31:0] smem [32];

  task automatic ref_access(input int w, input bit we, input logic [31:0] wd,
                            output bit hit, output logic [31:0] data);
    int s, t, way;
    s = w % 4; t = w / 4; hit = 0; way = 0;
    for (int k = 0; k < 2; k++)
      if (rv[s][k] && rt[s][k] == t) begin hit = 1; way = k; end
    if (hit) begin
      if (we) begin rdat[s][way] = wd; rdty[s][way] = 1; end
    end else begin
      if (!rv[s][0])      way = 0;
      else if (!rv[s][1]) way = 1;
      else                way = rlru[s] ? 1 : 0;
      if (rv[s][way] && rdty[s][way]) smem[rt[s][way] * 4 + s] = rdat[s][way];
      rv[s][way]   = 1;
      rt[s][way]   = t;
      rdat[s][way] = we ? wd : smem[w];
      rdty[s][way] = we;
    end
    data    = rdat[s][way];
    rlru[s] = (way == 0);
  endtask

  task automatic ref_flush(output int n);
    n = 0;
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 2; k++)
        if (rv[s][k] && rdty[s][k]) begin
          smem[rt[s][k] * 4 + s] = rdat[s][k];
          rdty[s][k] = 0;
          n++;
        end
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic access(input int w, input bit we, input logic [31:0] wd,
                        output bit got_hit, output logic [31:0] got_data,
                        output bit rdy_low);
    int h0;
    h0 = hit_count;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_word = 5'(w); req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rdy_low = !req_ready;
    while (!rsp_valid) @(negedge clk);
    got_data = rsp_rdata;
    got_hit  = (int'(hit_count) != h0);
  endtask

  task automatic do_op(input int w, input bit we, input logic [31:0] wd,
                       input string rq, output bit hit);
    bit eh, gh, rl;
    logic [31:0] ed, gd;
    ref_access(w, we, wd, eh, ed);
    access(w, we, wd, gh, gd, rl);
    ops++;
    chk(gh == eh, rq, "hit flag", 32'(gh), 32'(eh));
    chk(gd == ed, rq, "response data", gd, ed);
    chk(rl == !eh, "R8", "ready low after accept", 32'(rl), 32'(!eh));
    hit = gh;
  endtask

  task automatic do_flush(output bit seen);
    @(negedge clk);
    flush_req = 1'b1;
    seen = 0;
    while (!flush_busy) @(negedge clk);
    seen = 1;
    flush_req = 1'b0;
    while (flush_busy) @(negedge clk);
  endtask

  task automatic cmp_mem(input string rq);
    for (int i = 0; i < 32; i++) chk(mem[i] == smem[i], rq, "memory image", mem[i], smem[i]);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R3 watchdog expired: actual=%h expected=%h", 32'd1, 32'd0);
      summary();
      $finish;
    end
  end

  initial begin
    bit h, seen;
    int w0, r0, nd;
    logic [31:0] x;
    bit tr_exp [6];
    int tr_w   [6];
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_word = '0;
    req_wdata = '0; flush_req = 1'b0;
    for (int i = 0; i < 32; i++) smem[i] = seed_word(i);
    for (int s = 0; s < 4; s++) begin
      rlru[s] = 0;
      for (int k = 0; k < 2; k++) begin rv[s][k] = 0; rdty[s][k] = 0; rt[s][k] = 0; rdat[s][k] = '0; end
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(hit_count == 0, "R11", "hit_count", 32'(hit_count), 0);
    chk(miss_count == 0, "R11", "miss_count", 32'(miss_count), 0);
    chk(req_ready == 1, "R11", "req_ready", 32'(req_ready), 1);
    chk(!rsp_valid && !mem_valid && !flush_busy, "R11", "idle outputs",
        {29'b0, rsp_valid, mem_valid, flush_busy}, 0);

    // R10 trace: byte addresses 0,32,0,24,32,64 -> words 0,8,0,6,8,16
    tr_w = '{0, 8, 0, 6, 8, 16};
    tr_exp = '{0, 0, 1, 0, 1, 0};
    for (int i = 0; i < 6; i++) begin
      do_op(tr_w[i], 0, '0, "R10", h);
      chk(h == tr_exp[i], "R10", "trace outcome", 32'(h), 32'(tr_exp[i]));
    end

    // R4 store hit stays in cache
    w0 = wr_cnt;
    do_op(8, 1, 32'hFEED_0008, "R4", h);
    chk(h == 1, "R4", "store hit", 32'(h), 1);
    chk(wr_cnt == w0, "R4", "memory writes", 32'(wr_cnt), 32'(w0));
    chk(mem[8] == seed_word(8), "R4", "memory untouched", mem[8], seed_word(8));
    do_op(8, 0, '0, "R4", h);

    // R5 LRU victim (word 16 is older), then R6 dirty eviction of word 8
    do_op(24, 0, '0, "R5", h);
    w0 = wr_cnt; r0 = rd_cnt;
    do_op(0, 0, '0, "R6", h);
    chk(wr_cnt == w0 + 1, "R6", "writeback count", 32'(wr_cnt), 32'(w0 + 1));
    chk(last_wr_word == 5'd8, "R6", "writeback word", 32'(last_wr_word), 8);
    chk(mem[8] == 32'hFEED_0008, "R6", "written value", mem[8], 32'hFEED_0008);
    chk(last_wr_cyc < last_rd_cyc, "R6", "write before read", 32'(last_wr_cyc), 32'(last_rd_cyc));
    do_op(16, 0, '0, "R5", h);
    chk(h == 0, "R5", "evicted word misses", 32'(h), 0);

    // R7 store miss allocates
    w0 = wr_cnt; r0 = rd_cnt;
    do_op(12, 1, 32'h1234_ABCD, "R7", h);
    chk(rd_cnt == r0 + 1, "R7", "refill read", 32'(rd_cnt), 32'(r0 + 1));
    do_op(12, 0, '0, "R7", h);
    chk(h == 1, "R7", "allocated line hits", 32'(h), 1);
    chk(mem[12] == seed_word(12), "R7", "memory still old", mem[12], seed_word(12));

    // R1 and R5 within set 1: words 1,5,9 share a set
    begin
      int sw [6];
      bit se [6];
      sw = '{1, 5, 1, 9, 1, 5};
      se = '{0, 0, 1, 0, 1, 0};
      for (int i = 0; i < 6; i++) begin
        do_op(sw[i], 0, '0, "R1", h);
        chk(h == se[i], "R5", "set 1 replacement", 32'(h), 32'(se[i]));
      end
    end

    // R9 flush
    ref_flush(nd);
    w0 = wr_cnt;
    do_flush(seen);
    chk(seen, "R9", "flush_busy seen", 32'(seen), 1);
    chk(wr_cnt == w0 + nd, "R9", "dirty writebacks", 32'(wr_cnt), 32'(w0 + nd));
    cmp_mem("R9");
    w0 = wr_cnt;
    do_flush(seen);
    chk(wr_cnt == w0, "R9", "second flush writes", 32'(wr_cnt), 32'(w0));
    do_op(12, 0, '0, "R9", h);
    chk(h == 1, "R9", "line kept after flush", 32'(h), 1);

    // Sweep over all words with mixed loads and stores (R1, R2, R3, R5, R6, R7)
    x = 32'h1357_9BDF;
    for (int i = 0; i < 1500; i++) begin
      x = x * 32'd1103515245 + 32'd12345;
      do_op(int'(x[20:16]), x[9], x ^ 32'h3C3C_0000, "R3", h);
    end
    ref_flush(nd);
    w0 = wr_cnt;
    do_flush(seen);
    chk(wr_cnt == w0 + nd, "R9", "sweep writebacks", 32'(wr_cnt), 32'(w0 + nd));
    cmp_mem("R6");
    chk(int'(hit_count) + int'(miss_count) == ops, "R2", "counter total",
        32'(int'(hit_count) + int'(miss_count)), 32'(ops));

    done = 1;
    summary();
    $finish;
  end
endmodule